// File: doc/BRIEF.md
# Bus Ownership Controller with Selectable Release Policy

This block sits on the master side of a shared backplane. It turns local transfer requests into bus arbitration and tracks bus ownership. The local logic raises a request and waits for a start pulse. It then runs its transfer and reports completion. On the bus side the block raises a request line and waits for grant. While it owns the bus it holds an active-low busy line. It also watches an active-low clear line, which another master uses to ask for the bus.

A static policy input chooses between two behaviours:

- **Release after each transfer.** The block gives the bus back once every transfer has finished. It must arbitrate again for the next one.
- **Hold until asked.** The block keeps busy asserted between transfers. Only the first transfer of a burst has to arbitrate. Later transfers start directly from the owned state. Ownership is given up only when a clear has been seen, and never while a transfer is still running.

After every release, busy stays inactive for a programmable gap before the block may request again.

Top module: `bmrel_ctrl`

## Requirements
- R1: While reset is active and right after it, `bus_busy_n_o` is 1, `bus_req_o` is 0 and `xfer_start_o` is 0.
- R2: From the unowned idle state, a high `xfer_req_i` makes `bus_req_o` go high one cycle later, provided the release gap has elapsed. `bus_req_o` then stays high until grant is seen. It is never high while `bus_busy_n_o` is 0.
- R3: When grant is seen during a request, the next cycle has `bus_busy_n_o` = 0, `bus_req_o` = 0 and `xfer_start_o` = 1. `xfer_start_o` lasts exactly one cycle.
- R4: With `policy_hold_i` = 0 latched, a high `xfer_done_i` during a transfer makes `bus_busy_n_o` go to 1 on the next cycle.
- R5: With `policy_hold_i` = 0, every transfer of a burst needs its own request episode on `bus_req_o`.
- R6: With `policy_hold_i` = 1 latched, finishing a transfer while no clear is pending keeps `bus_busy_n_o` at 0. `bus_req_o` also stays 0 while the block sits owned and idle.
- R7: With `policy_hold_i` = 1, a burst of N transfers produces exactly one request episode. Each later transfer gets `xfer_start_o` one cycle after `xfer_req_i`, with no request.
- R8: While the block is owned and idle, `bus_clr_n_i` = 0 makes `bus_busy_n_o` go to 1 on the next cycle. Clear takes precedence over a simultaneous `xfer_req_i`, so no start pulse is issued.
- R9: A clear seen during a transfer, even a single-cycle pulse, does not release the bus before `xfer_done_i`. The release follows in the cycle after `xfer_done_i`.
- R10: After `bus_busy_n_o` rises, `bus_req_o` stays 0 for GAP_CYCLES+1 cycles. If `xfer_req_i` is held high, `bus_req_o` rises exactly GAP_CYCLES+1 cycles after busy rose.
- R11: `policy_hold_i` is sampled only while the block is unowned and idle. A change during ownership has no effect until the next release.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| policy_hold_i | input | 1 | 1 = hold bus until clear, 0 = release after each transfer |
| xfer_req_i | input | 1 | Local side has a transfer pending |
| xfer_done_i | input | 1 | Current transfer finishes this cycle |
| xfer_start_o | output | 1 | One-cycle pulse: begin the pending transfer |
| bus_req_o | output | 1 | Bus request to the arbiter, active high |
| bus_grant_i | input | 1 | Grant from the arbiter, active high |
| bus_busy_n_o | output | 1 | Bus busy, active low |
| bus_clr_n_i | input | 1 | Bus clear from another master, active low |

## Verification
The bench builds the block with SYNC_STAGES = 0, so grant and clear act on the very next edge, and with GAP_CYCLES = 2. Under those settings every hand-off cycle can be predicted exactly, including the precise cycle at which a re-request may appear after a release.

A sweep covers both policies and burst lengths of 1 to 4. For each case it counts the request episodes and start pulses and compares them with the arithmetic expectation: one request per burst when holding, one per transfer otherwise. Directed cases cover the following:

- a clear pulse arriving mid-transfer;
- clear and request arriving together;
- a policy change while the bus is owned.

// File: rtl/bmrel_pkg.sv
package bmrel_pkg;

   typedef enum logic [2:0] {
      ST_IDLE       = 3'd0,
      ST_REQUEST    = 3'd1,
      ST_OWN_ACTIVE = 3'd2,
      ST_OWN_IDLE   = 3'd3,
      ST_RELEASE    = 3'd4
   } own_state_e;

endpackage

// File: rtl/bmrel_sync.sv
module bmrel_sync #(
   parameter int STAGES = 2,
   parameter int WIDTH  = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d_i,
   output logic [WIDTH-1:0] q_o
);

   if (STAGES < 0) begin : g_bad_stages
      $error("bmrel_sync: STAGES must be non-negative");
   end
   if (WIDTH < 1) begin : g_bad_width
      $error("bmrel_sync: WIDTH must be at least 1");
   end

   if (STAGES == 0) begin : g_direct
      assign q_o = d_i;
   end else begin : g_chain
      logic [WIDTH-1:0] stage_q [STAGES];

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) stage_q[i] <= '0;
         end else begin
            stage_q[0] <= d_i;
            for (int i = 1; i < STAGES; i++) stage_q[i] <= stage_q[i-1];
         end
      end

      assign q_o = stage_q[STAGES-1];
   end

endmodule

// File: rtl/bmrel_gap_timer.sv
module bmrel_gap_timer #(
   parameter int GAP_CYCLES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic arm_i,
   output logic gap_done_o
);

   localparam int CW = (GAP_CYCLES < 2) ? 1 : $clog2(GAP_CYCLES);

   if (GAP_CYCLES < 1) begin : g_bad_gap
      $error("bmrel_gap_timer: GAP_CYCLES must be at least 1");
   end

   logic [CW-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (arm_i) begin
         cnt_q <= CW'(GAP_CYCLES - 1);
      end else if (cnt_q != '0) begin
         cnt_q <= cnt_q - 1'b1;
      end
   end

   assign gap_done_o = (cnt_q == '0);

endmodule

// File: rtl/bmrel_fsm.sv
module bmrel_fsm
   import bmrel_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       mode_i,
   input  logic       xfer_req_i,
   input  logic       xfer_done_i,
   input  logic       grant_i,
   input  logic       clr_i,
   input  logic       gap_done_i,
   output own_state_e state_o,
   output logic       start_o,
   output logic       req_o,
   output logic       busy_o
);

   own_state_e state_q, state_d;
   logic       mode_q;
   logic       start_q, start_d;
   logic       clr_pend_q;

   always_comb begin
      state_d = state_q;
      start_d = 1'b0;
      unique case (state_q)
         ST_IDLE: begin
            if (xfer_req_i && gap_done_i) state_d = ST_REQUEST;
         end
         ST_REQUEST: begin
            if (grant_i) begin
               state_d = ST_OWN_ACTIVE;
               start_d = 1'b1;
            end
         end
         ST_OWN_ACTIVE: begin
            if (xfer_done_i) begin
               if (!mode_q || clr_i || clr_pend_q) state_d = ST_RELEASE;
               else                                state_d = ST_OWN_IDLE;
            end
         end
         ST_OWN_IDLE: begin
            if (clr_i) begin
               state_d = ST_RELEASE;
            end else if (xfer_req_i) begin
               state_d = ST_OWN_ACTIVE;
               start_d = 1'b1;
            end
         end
         ST_RELEASE: state_d = ST_IDLE;
         default:    state_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q    <= ST_IDLE;
         start_q    <= 1'b0;
         mode_q     <= 1'b0;
         clr_pend_q <= 1'b0;
      end else begin
         state_q <= state_d;
         start_q <= start_d;
         if (state_q == ST_IDLE) mode_q <= mode_i;
         if (state_q != ST_OWN_ACTIVE)  clr_pend_q <= 1'b0;
         else if (clr_i && !xfer_done_i) clr_pend_q <= 1'b1;
      end
   end

   assign state_o = state_q;
   assign start_o = start_q;
   assign req_o   = (state_q == ST_REQUEST);
   assign busy_o  = (state_q == ST_OWN_ACTIVE) || (state_q == ST_OWN_IDLE);

   // R2: request and ownership are mutually exclusive
   a_r2_req_not_owned: assert property (@(posedge clk) disable iff (!rst_n)
      req_o |-> !busy_o);

   // R3: a start pulse only appears while the bus is owned
   a_r3_start_owned: assert property (@(posedge clk) disable iff (!rst_n)
      start_o |-> busy_o);

   // R3: grant during request leads to ownership and a start pulse
   a_r3_grant_takes: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_REQUEST && grant_i) |=> (busy_o && start_o && !req_o));

   // R3: the start pulse lasts one cycle
   a_r3_start_single: assert property (@(posedge clk) disable iff (!rst_n)
      start_o |=> !start_o);

   // R4: release-after-transfer policy frees the bus once done
   a_r4_done_frees: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_OWN_ACTIVE && xfer_done_i && !mode_q) |=> !busy_o);

   // R6: holding policy keeps the bus while no clear is seen
   a_r6_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_OWN_IDLE && !clr_i) |=> busy_o);

   // R7: a burst transfer starts without a request
   a_r7_burst_direct: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_OWN_IDLE && !clr_i && xfer_req_i) |=> (start_o && !req_o));

   // R9: never release while a transfer is still running
   a_r9_no_midxfer_release: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_OWN_ACTIVE && !xfer_done_i) |=> busy_o);

   // R11: the latched policy does not move while the bus is owned
   a_r11_mode_frozen: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_o && $past(busy_o)) |-> $stable(mode_q));

endmodule

// File: rtl/bmrel_ctrl.sv
module bmrel_ctrl
   import bmrel_pkg::*;
#(
   parameter int SYNC_STAGES = 2,
   parameter int GAP_CYCLES  = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic policy_hold_i,
   input  logic xfer_req_i,
   input  logic xfer_done_i,
   output logic xfer_start_o,
   output logic bus_req_o,
   input  logic bus_grant_i,
   output logic bus_busy_n_o,
   input  logic bus_clr_n_i
);

   localparam int SYNC_W = 2;

   logic [SYNC_W-1:0] bus_raw, bus_s;
   logic              grant_s, clr_s;
   logic              gap_done;
   logic              busy;
   own_state_e        state;

   assign bus_raw = {bus_grant_i, ~bus_clr_n_i};

   bmrel_sync #(
      .STAGES (SYNC_STAGES),
      .WIDTH  (SYNC_W)
   ) sync_i (
      .clk   (clk),
      .rst_n (rst_n),
      .d_i   (bus_raw),
      .q_o   (bus_s)
   );

   assign grant_s = bus_s[1];
   assign clr_s   = bus_s[0];

   bmrel_gap_timer #(
      .GAP_CYCLES (GAP_CYCLES)
   ) gap_i (
      .clk        (clk),
      .rst_n      (rst_n),
      .arm_i      (state == ST_RELEASE),
      .gap_done_o (gap_done)
   );

   bmrel_fsm fsm_i (
      .clk         (clk),
      .rst_n       (rst_n),
      .mode_i      (policy_hold_i),
      .xfer_req_i  (xfer_req_i),
      .xfer_done_i (xfer_done_i),
      .grant_i     (grant_s),
      .clr_i       (clr_s),
      .gap_done_i  (gap_done),
      .state_o     (state),
      .start_o     (xfer_start_o),
      .req_o       (bus_req_o),
      .busy_o      (busy)
   );

   assign bus_busy_n_o = ~busy;

   // R10: a request never follows a release directly
   a_r10_gap_after_release: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(bus_busy_n_o) |=> !bus_req_o);

   // R10: a request only starts while the gap timer has run out
   a_r10_req_after_gap: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(bus_req_o) |-> ($past(gap_done) && bus_busy_n_o));

endmodule

// File: tb/bmrel_ctrl_tb_top.sv
module bmrel_ctrl_tb_top;

   localparam int GAP = 2;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic policy_hold_i = 1'b0;
   logic xfer_req_i = 1'b0;
   logic xfer_done_i = 1'b0;
   logic bus_grant_i = 1'b0;
   logic bus_clr_n_i = 1'b1;
   logic xfer_start_o, bus_req_o, bus_busy_n_o;

   int checks = 0;
   int fails  = 0;
   int cycles = 0;

   always #4 clk = ~clk;

   bmrel_ctrl #(
      .SYNC_STAGES (0),
      .GAP_CYCLES  (GAP)
   ) dut_i (
      .clk           (clk),
      .rst_n         (rst_n),
      .policy_hold_i (policy_hold_i),
      .xfer_req_i    (xfer_req_i),
      .xfer_done_i   (xfer_done_i),
      .xfer_start_o  (xfer_start_o),
      .bus_req_o     (bus_req_o),
      .bus_grant_i   (bus_grant_i),
      .bus_busy_n_o  (bus_busy_n_o),
      .bus_clr_n_i   (bus_clr_n_i)
   );

   always @(posedge clk) begin
      cycles <= cycles + 1;
      if (cycles > 20000) begin
         checks = checks + 1;
         fails  = fails + 1;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("%0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   end

   task automatic step();
      @(posedge clk);
      #2;
   endtask

   task automatic chk(string tag, int act, int exp);
      checks = checks + 1;
      if (act != exp) begin
         fails = fails + 1;
         $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
      end
   endtask

   task automatic do_reset(bit hold);
      rst_n = 1'b0;
      policy_hold_i = hold;
      xfer_req_i = 0; xfer_done_i = 0; bus_grant_i = 0; bus_clr_n_i = 1;
      step();
      step();
      rst_n = 1'b1;
      step();
   endtask

   // request the bus, grant it, and leave the block in its first transfer
   task automatic acquire();
      xfer_req_i = 1;
      step();
      bus_grant_i = 1;
      step();
      bus_grant_i = 0;
      xfer_req_i = 0;
   endtask

   initial begin
      int n;
      // R1 reset state
      rst_n = 1'b0;
      step();
      chk("R1 busy_n in reset", bus_busy_n_o, 1);
      chk("R1 req in reset", bus_req_o, 0);
      chk("R1 start in reset", xfer_start_o, 0);
      do_reset(1'b0);
      chk("R1 busy_n after reset", bus_busy_n_o, 1);

      // R2/R3/R4/R10: release-after-transfer policy
      xfer_req_i = 1;
      step();
      chk("R2 req raised", bus_req_o, 1);
      step(); step();
      chk("R2 req held without grant", bus_req_o, 1);
      chk("R2 not busy while requesting", bus_busy_n_o, 1);
      bus_grant_i = 1;
      step();
      bus_grant_i = 0;
      chk("R3 busy_n after grant", bus_busy_n_o, 0);
      chk("R3 req dropped", bus_req_o, 0);
      chk("R3 start pulse", xfer_start_o, 1);
      step();
      chk("R3 start one cycle", xfer_start_o, 0);
      xfer_done_i = 1;
      step();
      xfer_done_i = 0;
      chk("R4 release after done", bus_busy_n_o, 1);
      n = 0;
      while (!bus_req_o && n < 20) begin
         step();
         n++;
      end
      chk("R10 gap before re-request", n, GAP + 1);
      chk("R5 re-arbitration request", bus_req_o, 1);

      // R6/R7/R8: hold policy, burst and clear priority
      do_reset(1'b1);
      acquire();
      chk("R3 start in hold mode", xfer_start_o, 1);
      xfer_done_i = 1;
      step();
      xfer_done_i = 0;
      chk("R6 busy kept after done", bus_busy_n_o, 0);
      step(); step(); step();
      chk("R6 busy kept while idle", bus_busy_n_o, 0);
      chk("R6 no request while owned", bus_req_o, 0);
      xfer_req_i = 1;
      step();
      xfer_req_i = 0;
      chk("R7 burst start without arbitration", xfer_start_o, 1);
      chk("R7 no request on burst", bus_req_o, 0);
      step();
      xfer_done_i = 1;
      step();
      xfer_done_i = 0;
      bus_clr_n_i = 0;
      xfer_req_i = 1;
      step();
      chk("R8 release on clear", bus_busy_n_o, 1);
      chk("R8 clear beats request", xfer_start_o, 0);
      bus_clr_n_i = 1;
      xfer_req_i = 0;

      // R9: clear pulse mid-transfer is deferred
      do_reset(1'b1);
      acquire();
      bus_clr_n_i = 0;
      step();
      bus_clr_n_i = 1;
      step(); step();
      chk("R9 no release mid-transfer", bus_busy_n_o, 0);
      xfer_done_i = 1;
      step();
      xfer_done_i = 0;
      chk("R9 deferred release after done", bus_busy_n_o, 1);

      // R11: policy change while owned is ignored until idle
      do_reset(1'b1);
      acquire();
      policy_hold_i = 0;
      step();
      xfer_done_i = 1;
      step();
      xfer_done_i = 0;
      chk("R11 old policy kept while owned", bus_busy_n_o, 0);
      bus_clr_n_i = 0;
      step();
      bus_clr_n_i = 1;
      chk("R11 released by clear", bus_busy_n_o, 1);
      step(); step(); step();
      acquire();
      xfer_done_i = 1;
      step();
      xfer_done_i = 0;
      chk("R11 new policy after idle", bus_busy_n_o, 1);

      // R5/R7 sweep: both policies, burst lengths 1..4
      for (int m = 0; m < 2; m++) begin
         for (int len = 1; len <= 4; len++) begin
            int reqs;
            int starts;
            bit prev;
            do_reset(m[0]);
            reqs = 0; starts = 0; prev = 0;
            for (int k = 0; k < len; k++) begin
               xfer_req_i = 1;
               for (int c = 0; c < 40; c++) begin
                  if (bus_req_o && !prev) reqs++;
                  prev = bus_req_o;
                  bus_grant_i = bus_req_o;
                  step();
                  if (xfer_start_o) begin
                     starts++;
                     break;
                  end
               end
               bus_grant_i = 0;
               xfer_req_i = 0;
               prev = bus_req_o;
               step();
               xfer_done_i = 1;
               step();
               xfer_done_i = 0;
            end
            if (m == 0) begin
               chk("R5 requests per transfer", reqs, len);
               chk("R4 free after burst", bus_busy_n_o, 1);
            end else begin
               chk("R7 one request per burst", reqs, 1);
               chk("R6 held after burst", bus_busy_n_o, 0);
               bus_clr_n_i = 0;
               step();
               bus_clr_n_i = 1;
               chk("R8 clear ends burst", bus_busy_n_o, 1);
            end
            chk("R3 start pulses in burst", starts, len);
         end
      end

      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

endmodule